// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-visible control and status register set of a multi-channel DMA controller that has up to 64 channels. Software reaches it through a simple 32-bit write port with byte enables and a combinational read port. It holds a global control word, a read-only error status word, and 64-bit per-channel vectors split into a high word (channels 63..32) and a low word (channels 31..0). The vectors are request enable, error-interrupt enable, interrupt request, error flag and hardware-request status.

Besides whole-word writes, most per-channel bits change through byte-wide command registers. Software writes a channel number into the matching byte lane, and the block sets or clears only that channel's bit. No read-modify-write of a mask is needed. The channel engines feed back completion and error events. The block drives per-channel request enables, one-cycle start and done-clear strobes, the three control mode bits and one interrupt line.

Top module: `dma_chreg_file`

## Requirements
- R1: After reset, every readable word is zero. `ch_req_en`, `ch_start`, `ch_done_clr`, the control outputs and `irq_out` are low.
- R2: The control word at byte offset 0x00 keeps only bit 31 (dynamic clocking), bit 3 (round-robin group arbitration) and bit 2 (round-robin channel arbitration). These drive `ctl_dyn_clk`, `ctl_grp_rr` and `ctl_ch_rr`. All other bits read as zero.
- R3: The request-enable words (high at 0x08, low at 0x0C) and the error-interrupt-enable words (high at 0x10, low at 0x14) are written and read as whole words. High words hold channels 63..32 at bits 31..0, and low words hold channels 31..0. `ch_req_en` follows the request-enable bits.
- R4: Command word 0x18 has four byte lanes. Byte lane k is byte offset k, carried on `bus_wdata[8k+7:8k]` with `bus_be[k]`. Lane 0 sets a channel's request enable and lane 1 clears it. Lane 2 sets its error-interrupt enable and lane 3 clears it. The channel is the byte value, and several lanes may act in one write.
- R5: A command byte whose value is 64 or more (or not below the channel count) changes nothing and raises no strobe.
- R6: A `ev_done` pulse sets that channel's interrupt-request bit (high word at 0x20, low at 0x24). Lane 0 of command word 0x1C clears one channel's bit. Writing ones to an interrupt-request word clears those bits.
- R7: A `ev_err` pulse sets that channel's error bit (high word at 0x28, low at 0x2C). Lane 1 of 0x1C clears one channel's bit, and writing ones clears those bits. An event that arrives in the same cycle as a clear of the same bit wins.
- R8: A write to lane 2 of 0x1C pulses `ch_start` for that channel for exactly one cycle, in the cycle after the write edge. Lane 3 pulses `ch_done_clr` the same way.
- R9: `hw_req` reads back at 0x30 (channels 63..32) and 0x34 (channels 31..0).
- R10: The error status word at 0x04 is read-only. Its layout is: bit 31 valid; bit 15 `err_cause[9]` (group priority); bit 14 `err_cause[8]` (channel priority); bits 13..8 channel; bits 7..0 `err_cause[7:0]` (source address, source offset, destination address, destination offset, count configuration, chaining configuration, source bus, destination bus). The word records only the first error while it is not valid. If several channels err in that cycle, it records the lowest-numbered one.
- R11: The valid bit is cleared only by a clear-error command (0x1C lane 1) naming the recorded channel. A clear naming another channel, or a ones write to the error words, leaves the status word unchanged.
- R12: `irq_out` is high exactly when some interrupt-request bit is set, or some error bit is set whose error-interrupt enable is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, takes effect at the rising edge |
| bus_addr | input | ADDR_W | Byte address (bits 1:0 ignored) for reads and writes |
| bus_be | input | 4 | Byte enables, used by the command words |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_done | input | NCH | Per-channel completion events |
| ev_err | input | NCH | Per-channel error events |
| err_cause | input | 10 | Error cause bits that accompany `ev_err` |
| hw_req | input | NCH | Per-channel hardware request status |
| ch_req_en | output | NCH | Per-channel request enable |
| ch_start | output | NCH | One-cycle start strobe |
| ch_done_clr | output | NCH | One-cycle done-clear strobe |
| ctl_dyn_clk | output | 1 | Dynamic clocking enable |
| ctl_grp_rr | output | 1 | Round-robin group arbitration |
| ctl_ch_rr | output | 1 | Round-robin channel arbitration |
| irq_out | output | 1 | Combined interrupt |

## Verification
The command decoder is driven with channel numbers that land in the low word, in the high word and out of range (64 and 255). This shows whether the number is decoded into the right word and bit, and whether illegal values are truly dropped. Single-lane and multi-lane writes to the same word separate set from clear and show which lane is decoded. Error events are applied in a fixed order: one on a channel whose error interrupt is masked, a second while the status is already valid, and two channels at once. This order tells first-error hold apart from overwrite and lowest-channel choice apart from highest. The clears mix the recorded channel, another channel and ones writes, and one ones write coincides with a new event, which exposes any clear priority that drops events.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;

  localparam int MAXCH = 64;
  localparam int CAUSE_W = 10;

  // word indices (byte offset / 4)
  localparam logic [5:0] W_CTRL   = 6'h00;
  localparam logic [5:0] W_ESTAT  = 6'h01;
  localparam logic [5:0] W_REQ_HI = 6'h02;
  localparam logic [5:0] W_REQ_LO = 6'h03;
  localparam logic [5:0] W_EIE_HI = 6'h04;
  localparam logic [5:0] W_EIE_LO = 6'h05;
  localparam logic [5:0] W_CMD_A  = 6'h06;
  localparam logic [5:0] W_CMD_B  = 6'h07;
  localparam logic [5:0] W_INT_HI = 6'h08;
  localparam logic [5:0] W_INT_LO = 6'h09;
  localparam logic [5:0] W_ERR_HI = 6'h0A;
  localparam logic [5:0] W_ERR_LO = 6'h0B;
  localparam logic [5:0] W_HRS_HI = 6'h0C;
  localparam logic [5:0] W_HRS_LO = 6'h0D;

  // control word bit positions
  localparam int CB_DYNCLK = 31;
  localparam int CB_GRPRR  = 3;
  localparam int CB_CHRR   = 2;

  // one-hot channel vector for a command byte, empty when out of range
  function automatic logic [MAXCH-1:0] chan_onehot(input logic [7:0] v, input int nch);
    logic [MAXCH-1:0] r;
    r = '0;
    if (int'(v) < nch) r[v[5:0]] = 1'b1;
    return r;
  endfunction

  // index of the lowest set bit (0 when empty)
  function automatic logic [5:0] lowest_set(input logic [MAXCH-1:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = MAXCH - 1; i >= 0; i--) begin
      if (v[i]) r = 6'(i);
    end
    return r;
  endfunction

  // error status word layout
  function automatic logic [31:0] pack_estat(input logic vld, input logic [5:0] ch,
                                             input logic [CAUSE_W-1:0] cause);
    return {vld, 15'b0, cause[9:8], ch, cause[7:0]};
  endfunction

endpackage

// File: rtl/dmacr_cmd_decode.sv
module dmacr_cmd_decode
  import dmacr_pkg::*;
#(
  parameter int NCH = 64
) (
  input  logic             wr_ok,
  input  logic [5:0]       widx,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  output logic [MAXCH-1:0] set_req,
  output logic [MAXCH-1:0] clr_req,
  output logic [MAXCH-1:0] set_eie,
  output logic [MAXCH-1:0] clr_eie,
  output logic [MAXCH-1:0] clr_int,
  output logic [MAXCH-1:0] clr_err,
  output logic [MAXCH-1:0] start_v,
  output logic [MAXCH-1:0] clr_done
);
  localparam int LANES = 4;

  logic [MAXCH-1:0] vec_a [LANES];
  logic [MAXCH-1:0] vec_b [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic hit_a, hit_b;
    assign hit_a    = wr_ok && (widx == W_CMD_A) && be[k];
    assign hit_b    = wr_ok && (widx == W_CMD_B) && be[k];
    assign vec_a[k] = hit_a ? chan_onehot(wdata[8*k +: 8], NCH) : '0;
    assign vec_b[k] = hit_b ? chan_onehot(wdata[8*k +: 8], NCH) : '0;
  end

  assign set_req  = vec_a[0];
  assign clr_req  = vec_a[1];
  assign set_eie  = vec_a[2];
  assign clr_eie  = vec_a[3];
  assign clr_int  = vec_b[0];
  assign clr_err  = vec_b[1];
  assign start_v  = vec_b[2];
  assign clr_done = vec_b[3];

  // R8: a command names at most one channel per lane
  always_comb begin
    a_r8_one_chan_per_lane: assert ($onehot0(start_v) && $onehot0(clr_done));
  end

endmodule

// File: rtl/dmacr_chan_bits.sv
module dmacr_chan_bits
  import dmacr_pkg::*;
#(
  parameter int NCH = 64,
  parameter bit W1C = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAXCH-1:0] set_v,
  input  logic [MAXCH-1:0] clr_v,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [31:0]      wdata,
  output logic [MAXCH-1:0] q
);
  localparam logic [MAXCH-1:0] CH_MASK = {MAXCH{1'b1}} >> (MAXCH - NCH);

  logic [MAXCH-1:0] base, nxt;

  if (W1C) begin : g_w1c
    always_comb begin
      base = q;
      if (wr_hi) base[63:32] = q[63:32] & ~wdata;
      if (wr_lo) base[31:0]  = q[31:0]  & ~wdata;
    end
  end else begin : g_rw
    always_comb begin
      base = q;
      if (wr_hi) base[63:32] = wdata;
      if (wr_lo) base[31:0]  = wdata;
    end
  end

  // a new set wins over any clear in the same cycle
  assign nxt = ((base & ~clr_v) | set_v) & CH_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R7 (and R6, R4): every requested set is visible in the next cycle
  a_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0) |=> ((q & $past(set_v & CH_MASK)) == $past(set_v & CH_MASK)));

endmodule

// File: rtl/dmacr_err_capture.sv
module dmacr_err_capture
  import dmacr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MAXCH-1:0]   ev_err,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [MAXCH-1:0]   clr_err,
  output logic [31:0]        status
);
  logic               vld_q;
  logic [5:0]         ch_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               clear_hit;
  logic               any_err;

  assign clear_hit = vld_q && clr_err[ch_q];
  assign any_err   = |ev_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      ch_q    <= '0;
      cause_q <= '0;
    end else if (clear_hit) begin
      vld_q   <= 1'b0;
      ch_q    <= '0;
      cause_q <= '0;
    end else if (!vld_q && any_err) begin
      vld_q   <= 1'b1;
      ch_q    <= lowest_set(ev_err);
      cause_q <= cause;
    end
  end

  assign status = pack_estat(vld_q, ch_q, cause_q);

  // R10: a recorded error is held until its own channel is cleared
  a_r10_first_held: assert property (@(posedge clk) disable iff (!rst_n)
    (status[31] && !clr_err[status[13:8]]) |=> $stable(status));

  // R11: clearing the recorded channel drops the valid bit
  a_r11_clear_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (status[31] && clr_err[status[13:8]]) |=> !status[31]);

endmodule

// File: rtl/dma_chreg_file.sv
module dma_chreg_file
  import dmacr_pkg::*;
#(
  parameter int NCH    = 64,
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NCH-1:0]     ev_done,
  input  logic [NCH-1:0]     ev_err,
  input  logic [CAUSE_W-1:0] err_cause,
  input  logic [NCH-1:0]     hw_req,
  output logic [NCH-1:0]     ch_req_en,
  output logic [NCH-1:0]     ch_start,
  output logic [NCH-1:0]     ch_done_clr,
  output logic               ctl_dyn_clk,
  output logic               ctl_grp_rr,
  output logic               ctl_ch_rr,
  output logic               irq_out
);
  localparam logic [MAXCH-1:0] CH_MASK = {MAXCH{1'b1}} >> (MAXCH - NCH);

  // address decode
  logic [ADDR_W-1:0] addr_hi;
  logic              in_range;
  logic [5:0]        widx;
  logic              wr_ok;

  assign addr_hi  = bus_addr >> 8;
  assign in_range = (addr_hi == '0);
  assign widx     = bus_addr[7:2];
  assign wr_ok    = bus_wr && in_range;

  // widened event inputs
  logic [MAXCH-1:0] done_w, err_w, hrs_w;
  assign done_w = MAXCH'(ev_done);
  assign err_w  = MAXCH'(ev_err);
  assign hrs_w  = MAXCH'(hw_req);

  // command decode
  logic [MAXCH-1:0] set_req, clr_req, set_eie, clr_eie;
  logic [MAXCH-1:0] clr_int, clr_err, start_v, clr_done;

  dmacr_cmd_decode #(.NCH(NCH)) u_dec (
    .wr_ok    (wr_ok),
    .widx     (widx),
    .be       (bus_be),
    .wdata    (bus_wdata),
    .set_req  (set_req),
    .clr_req  (clr_req),
    .set_eie  (set_eie),
    .clr_eie  (clr_eie),
    .clr_int  (clr_int),
    .clr_err  (clr_err),
    .start_v  (start_v),
    .clr_done (clr_done)
  );

  // per-channel banks
  logic [MAXCH-1:0] req_q, eie_q, int_q, errf_q;

  dmacr_chan_bits #(.NCH(NCH), .W1C(1'b0)) u_req (
    .clk(clk), .rst_n(rst_n), .set_v(set_req), .clr_v(clr_req),
    .wr_hi(wr_ok && widx == W_REQ_HI), .wr_lo(wr_ok && widx == W_REQ_LO),
    .wdata(bus_wdata), .q(req_q)
  );

  dmacr_chan_bits #(.NCH(NCH), .W1C(1'b0)) u_eie (
    .clk(clk), .rst_n(rst_n), .set_v(set_eie), .clr_v(clr_eie),
    .wr_hi(wr_ok && widx == W_EIE_HI), .wr_lo(wr_ok && widx == W_EIE_LO),
    .wdata(bus_wdata), .q(eie_q)
  );

  dmacr_chan_bits #(.NCH(NCH), .W1C(1'b1)) u_int (
    .clk(clk), .rst_n(rst_n), .set_v(done_w & CH_MASK), .clr_v(clr_int),
    .wr_hi(wr_ok && widx == W_INT_HI), .wr_lo(wr_ok && widx == W_INT_LO),
    .wdata(bus_wdata), .q(int_q)
  );

  dmacr_chan_bits #(.NCH(NCH), .W1C(1'b1)) u_err (
    .clk(clk), .rst_n(rst_n), .set_v(err_w & CH_MASK), .clr_v(clr_err),
    .wr_hi(wr_ok && widx == W_ERR_HI), .wr_lo(wr_ok && widx == W_ERR_LO),
    .wdata(bus_wdata), .q(errf_q)
  );

  // first-error status
  logic [31:0] estat;

  dmacr_err_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_err  (err_w & CH_MASK),
    .cause   (err_cause),
    .clr_err (clr_err),
    .status  (estat)
  );

  // control word and strobes
  logic             dyn_q, grp_q, chrr_q;
  logic [MAXCH-1:0] start_q, dclr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dyn_q   <= 1'b0;
      grp_q   <= 1'b0;
      chrr_q  <= 1'b0;
      start_q <= '0;
      dclr_q  <= '0;
    end else begin
      if (wr_ok && widx == W_CTRL) begin
        dyn_q  <= bus_wdata[CB_DYNCLK];
        grp_q  <= bus_wdata[CB_GRPRR];
        chrr_q <= bus_wdata[CB_CHRR];
      end
      start_q <= start_v;
      dclr_q  <= clr_done;
    end
  end

  assign ctl_dyn_clk = dyn_q;
  assign ctl_grp_rr  = grp_q;
  assign ctl_ch_rr   = chrr_q;
  assign ch_req_en   = req_q[NCH-1:0];
  assign ch_start    = start_q[NCH-1:0];
  assign ch_done_clr = dclr_q[NCH-1:0];

  // combined interrupt
  logic any_int, any_err_irq;
  assign any_int     = |int_q;
  assign any_err_irq = |(errf_q & eie_q);
  assign irq_out     = any_int || any_err_irq;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (in_range) begin
      case (widx)
        W_CTRL:   bus_rdata = {dyn_q, 27'b0, grp_q, chrr_q, 2'b0};
        W_ESTAT:  bus_rdata = estat;
        W_REQ_HI: bus_rdata = req_q[63:32];
        W_REQ_LO: bus_rdata = req_q[31:0];
        W_EIE_HI: bus_rdata = eie_q[63:32];
        W_EIE_LO: bus_rdata = eie_q[31:0];
        W_INT_HI: bus_rdata = int_q[63:32];
        W_INT_LO: bus_rdata = int_q[31:0];
        W_ERR_HI: bus_rdata = errf_q[63:32];
        W_ERR_LO: bus_rdata = errf_q[31:0];
        W_HRS_HI: bus_rdata = hrs_w[63:32];
        W_HRS_LO: bus_rdata = hrs_w[31:0];
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R5: out-of-range command bytes on both enable lanes leave enables untouched
  a_r5_bad_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[7:2] == W_CMD_A && int'(bus_wdata[7:0]) >= NCH
     && int'(bus_wdata[15:8]) >= NCH) |=> $stable(ch_req_en));

  // R8: start strobe names at most one channel and lasts one cycle
  a_r8_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_start));

  // R12: a completion event always raises the interrupt
  a_r12_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done != '0) |=> irq_out);

  // R6: ones written to the low request word with no event empty it
  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(8'h24) && bus_wdata == 32'hFFFF_FFFF
     && ev_done[31:0] == '0) |=> (int_q[31:0] == '0));

endmodule

// File: tb/tb_dma_chreg_file.sv
`timescale 1ns/1ps
module tb_dma_chreg_file;
  localparam int NCH = 64;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [3:0]    bus_be = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NCH-1:0] ev_done = '0, ev_err = '0, hw_req = '0;
  logic [9:0]    err_cause = '0;
  logic [NCH-1:0] ch_req_en, ch_start, ch_done_clr;
  logic ctl_dyn_clk, ctl_grp_rr, ctl_ch_rr, irq_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_chreg_file #(.NCH(NCH), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_done(ev_done), .ev_err(ev_err), .err_cause(err_cause), .hw_req(hw_req),
    .ch_req_en(ch_req_en), .ch_start(ch_start), .ch_done_clr(ch_done_clr),
    .ctl_dyn_clk(ctl_dyn_clk), .ctl_grp_rr(ctl_grp_rr), .ctl_ch_rr(ctl_ch_rr),
    .irq_out(irq_out)
  );

  // row: write addr, byte enables, write data, read addr, expected read
  localparam int NROW = 12;
  localparam logic [83:0] TBL [NROW] = '{
    {8'h08, 4'hF, 32'hA5A5_0001, 8'h08, 32'hA5A5_0001}, // R3 high enable word
    {8'h0C, 4'hF, 32'h0000_00F0, 8'h0C, 32'h0000_00F0}, // R3 low enable word
    {8'h18, 4'h1, 32'h0000_0001, 8'h0C, 32'h0000_00F2}, // R4 set ch1
    {8'h18, 4'h2, 32'h0000_0400, 8'h0C, 32'h0000_00E2}, // R4 clear ch4
    {8'h18, 4'h1, 32'h0000_0028, 8'h08, 32'hA5A5_0101}, // R4 set ch40
    {8'h18, 4'h1, 32'h0000_0040, 8'h0C, 32'h0000_00E2}, // R5 set 64 ignored
    {8'h18, 4'h2, 32'h0000_FF00, 8'h08, 32'hA5A5_0101}, // R5 clear 255 ignored
    {8'h18, 4'h4, 32'h0021_0000, 8'h10, 32'h0000_0002}, // R4 set err-ie ch33
    {8'h18, 4'h8, 32'h2100_0000, 8'h10, 32'h0000_0000}, // R4 clear err-ie ch33
    {8'h00, 4'hF, 32'hFFFF_FFFF, 8'h00, 32'h8000_000C}, // R2 control bits
    {8'h14, 4'hF, 32'h1234_5678, 8'h14, 32'h1234_5678}, // R3 err-ie low word
    {8'h04, 4'hF, 32'hFFFF_FFFF, 8'h04, 32'h0000_0000}  // R10 status read-only
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] dn, input logic [NCH-1:0] er, input logic [9:0] cz);
    @(negedge clk);
    ev_done = dn; ev_err = er; err_cause = cz;
    @(negedge clk);
    ev_done = '0; ev_err = '0; err_cause = '0;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, 64'(d), 64'(exp));
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a <= 8'h34; a += 4) begin
      rd(8'(a), d);
      chk("R1 reset read", 64'(d), 64'h0);
    end
    chk("R1 reset outputs", {ch_req_en}, 64'h0);
    chk("R1 reset strobes", 64'(ch_start | ch_done_clr), 64'h0);
    chk("R1 reset ctl/irq", 64'({ctl_dyn_clk, ctl_grp_rr, ctl_ch_rr, irq_out}), 64'h0);

    // table walk
    for (int i = 0; i < NROW; i++) begin
      wr(TBL[i][83:76], TBL[i][75:72], TBL[i][71:40]);
      rd(TBL[i][39:32], d);
      checks++;
      if (d !== TBL[i][31:0]) begin
        errors++;
        $display("FAIL table row %0d (R2/R3/R4/R5/R10): actual %h expected %h",
                 i, d, TBL[i][31:0]);
      end
    end
    chk("R3 ch_req_en port", ch_req_en, 64'hA5A5_0101_0000_00E2);
    chk("R2 ctl outputs", 64'({ctl_dyn_clk, ctl_grp_rr, ctl_ch_rr}), 64'h7);

    // R8: start and done-clear strobes
    wr(8'h1C, 4'h4, 32'h0003_0000);
    chk("R8 start pulse", ch_start, 64'h8);
    @(negedge clk);
    chk("R8 start one cycle", ch_start, 64'h0);
    wr(8'h1C, 4'h8, 32'h3200_0000);
    chk("R8 done-clear pulse", ch_done_clr, 64'h1 << 50);
    wr(8'h1C, 4'h4, 32'h0040_0000);
    chk("R5 start 64 ignored", ch_start, 64'h0);

    // R6: completion events
    pulse(64'h80, '0, '0);
    rchk("R6 int low set", 8'h24, 32'h80);
    chk("R12 irq from int", 64'(irq_out), 64'h1);
    wr(8'h1C, 4'h1, 32'h0000_0007);
    rchk("R6 clear int cmd", 8'h24, 32'h0);
    chk("R12 irq low after clear", 64'(irq_out), 64'h0);
    pulse(64'h1 << 35, '0, '0);
    rchk("R6 int high set", 8'h20, 32'h8);
    wr(8'h20, 4'hF, 32'hFFFF_FFFF);
    rchk("R6 int ones clear", 8'h20, 32'h0);

    // R7/R10/R11/R12: error events, err-ie low = 12345678
    pulse('0, 64'h4, 10'h281);
    rchk("R7 err bit ch2", 8'h2C, 32'h4);
    chk("R12 masked err no irq", 64'(irq_out), 64'h0);
    rchk("R10 status first error", 8'h04, 32'h8000_8281);
    pulse('0, 64'h10, 10'h3FF);
    rchk("R7 err bit ch4", 8'h2C, 32'h14);
    chk("R12 enabled err irq", 64'(irq_out), 64'h1);
    rchk("R10 status held", 8'h04, 32'h8000_8281);
    wr(8'h1C, 4'h2, 32'h0000_0400);
    rchk("R7 clear err ch4", 8'h2C, 32'h4);
    rchk("R11 other channel keeps valid", 8'h04, 32'h8000_8281);
    chk("R12 irq low again", 64'(irq_out), 64'h0);
    wr(8'h1C, 4'h2, 32'h0000_0200);
    rchk("R11 recorded channel clears", 8'h04, 32'h0);
    rchk("R7 err low empty", 8'h2C, 32'h0);
    pulse('0, 64'h1200, 10'h005);
    rchk("R10 lowest channel", 8'h04, 32'h8000_0905);
    chk("R12 irq on ch9/12", 64'(irq_out), 64'h1);
    wr(8'h2C, 4'hF, 32'hFFFF_FFFF);
    rchk("R7 err ones clear", 8'h2C, 32'h0);
    chk("R12 irq after ones clear", 64'(irq_out), 64'h0);
    rchk("R11 ones write keeps status", 8'h04, 32'h8000_0905);

    // R7: event wins over same-cycle ones clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h28; bus_be = 4'hF; bus_wdata = 32'hFFFF_FFFF;
    ev_err = 64'h1 << 33;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; ev_err = '0;
    rchk("R7 event beats clear", 8'h28, 32'h2);

    // R9: hardware request status
    hw_req = 64'hDEAD_BEEF_0BAD_F00D;
    rchk("R9 hw req high", 8'h30, 32'hDEAD_BEEF);
    rchk("R9 hw req low", 8'h34, 32'h0BAD_F00D);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog (R1): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule